// File: doc/BRIEF.md
# SPI Configuration Register Port

This block is a slave serial port, clocked by the master, that reads and writes a small bank of 8-bit configuration registers addressed by six bits. The serial clock, select and data inputs are brought into the system clock domain through synchronizers and edge detectors, so every serial edge becomes a one-cycle event there. A frame opens with a two-bit command sent first. Two command values are defined: one for write and one for read. Six address bits follow, MSB first. A write then carries eight data bits. After the address of a read, the port pauses for a programmable number of system cycles, then returns the register contents on its output line, MSB first.

Changes to the registers are gated at two levels. A global key register has to hold its unlock code before any write other than to itself is taken. A second key guards the mode register. The mode register selects alignment mode. While alignment mode is selected, the locate-test and tilt enables are driven high. A reset clears both keys and puts the mode register back to its default. Writing the default value back to the mode register also leaves alignment mode.

Top module: `spi_cfg_port`

## Requirements
- R1: After reset, `miso_o`, `locate_en_o` and `tilt_en_o` are 0. `miso_o` stays 0 whenever `csn_i` is high.
- R2: A frame is sent MSB first, with `mosi_i` sampled on rising `sck_i`. A write is command bits 0 then 1 (code 01), then a 6-bit address, then 8 data bits. The write takes effect only when the 16th rising edge arrives.
- R3: A read is command bits 1 then 0 (code 10), then a 6-bit address. The data is returned MSB first on `miso_o`: the MSB is presented when the pause ends, and each following bit is presented after a falling `sck_i` edge. Addresses that map to no register read as 0x00.
- R4: Until 0xEB is written to address 0x1B, writes to every other address are discarded. Reading 0x1B returns 0x01 while the global key is set and 0x00 otherwise.
- R5: Writing any value other than 0xEB to 0x1B clears the global key. Later writes to other addresses are then discarded again.
- R6: The mode register at 0x10 changes only when both keys are set. The second key is set by writing 0xAB to 0x11, and reading 0x11 returns 0x01 while it is set. Writing another value to 0x11 clears it.
- R7: `locate_en_o` and `tilt_en_o` are 1 exactly while the mode register holds 0x11. Writing 0x01 to the mode register clears them.
- R8: Reset clears both keys and sets the mode register to 0x01. Reset clears the general registers at addresses 0x00 to NUM_GP-1 to 0x00, and those registers read back what was last written to them.
- R9: Raising `csn_i` before the 16th rising edge aborts the frame with no write, and the next frame is decoded from its first bit.
- R10: For GAP_CYC system cycles after the address of a read, `miso_o` stays 0 and rising `sck_i` edges are ignored.
- R11: Frames carrying command 00 or 11 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock from the master |
| csn_i | input | 1 | Frame select, active low |
| mosi_i | input | 1 | Serial data into the port |
| miso_o | output | 1 | Serial read data out of the port |
| locate_en_o | output | 1 | Enable for the locate-test output in alignment mode |
| tilt_en_o | output | 1 | Enable for the tilt output in alignment mode |

## Verification
Each serial edge reaches the frame logic about four system cycles after the pin changes: two synchronizer stages, one edge register, then the state update. The bench holds every serial clock phase for eight system cycles, so a write has taken effect, and the enables have followed, before the bench lowers the serial clock after the 16th rising edge. The bench samples each returned read bit just before it raises the serial clock, eight cycles after the falling edge that presented the bit. It checks the quiet line partway into the pause and waits well past GAP_CYC before it takes the first data bit.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;
  localparam int CMD_W  = 2;
  localparam int HDR_BITS   = CMD_W + ADDR_W;
  localparam int FRAME_BITS = HDR_BITS + DATA_W;

  localparam logic [CMD_W-1:0] CMD_WR = 2'b01;
  localparam logic [CMD_W-1:0] CMD_RD = 2'b10;

  localparam logic [ADDR_W-1:0] A_GKEY = 6'h1B;
  localparam logic [ADDR_W-1:0] A_AKEY = 6'h11;
  localparam logic [ADDR_W-1:0] A_MODE = 6'h10;

  localparam logic [DATA_W-1:0] GKEY_VAL   = 8'hEB;
  localparam logic [DATA_W-1:0] AKEY_VAL   = 8'hAB;
  localparam logic [DATA_W-1:0] MODE_RST   = 8'h01;
  localparam logic [DATA_W-1:0] MODE_ALIGN = 8'h11;
endpackage

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= RST_VAL;
    else         chain_q[0] <= d_i;
  end

  for (genvar gi = 1; gi < STAGES; gi++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[gi] <= RST_VAL;
      else         chain_q[gi] <= chain_q[gi-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/spi_cfg_frame.sv
module spi_cfg_frame
  import spi_cfg_pkg::*;
#(
  parameter int GAP_CYC = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mosi_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              miso_o,
  output logic              gap_busy_o,
  output logic [$clog2(FRAME_BITS+1)-1:0] bit_cnt_o
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam int GAP_W = $clog2(GAP_CYC + 1);
  localparam int SH_W  = FRAME_BITS - 1;

  logic [CNT_W-1:0]  cnt_q;
  logic [SH_W-1:0]   sh_q;
  logic [GAP_W-1:0]  gap_q;
  logic [DATA_W-1:0] tx_q;
  logic              rd_act_q;

  logic [CMD_W-1:0]  hdr_cmd, full_cmd;
  logic [ADDR_W-1:0] hdr_addr, full_addr;
  logic [DATA_W-1:0] full_data;

  // decode views of the shift register at the last bit of each phase
  assign hdr_cmd   = sh_q[HDR_BITS-2 -: CMD_W];
  assign hdr_addr  = {sh_q[ADDR_W-2:0], mosi_i};
  assign full_cmd  = sh_q[SH_W-1 -: CMD_W];
  assign full_addr = sh_q[SH_W-1-CMD_W -: ADDR_W];
  assign full_data = {sh_q[DATA_W-2:0], mosi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      sh_q      <= '0;
      gap_q     <= '0;
      tx_q      <= '0;
      rd_act_q  <= 1'b0;
      rd_addr_o <= '0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (!sel_i) begin
        cnt_q    <= '0;
        gap_q    <= '0;
        tx_q     <= '0;
        rd_act_q <= 1'b0;
      end else if (gap_q != '0) begin
        gap_q <= gap_q - 1'b1;
        if (gap_q == GAP_W'(1)) begin
          tx_q     <= rd_data_i;
          rd_act_q <= 1'b1;
        end
      end else if (rise_i && cnt_q < CNT_W'(FRAME_BITS)) begin
        sh_q  <= {sh_q[SH_W-2:0], mosi_i};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(HDR_BITS - 1) && hdr_cmd == CMD_RD) begin
          rd_addr_o <= hdr_addr;
          gap_q     <= GAP_W'(GAP_CYC);
        end
        if (cnt_q == CNT_W'(FRAME_BITS - 1) && full_cmd == CMD_WR) begin
          wr_en_o   <= 1'b1;
          wr_addr_o <= full_addr;
          wr_data_o <= full_data;
        end
      end else if (fall_i && rd_act_q && cnt_q > CNT_W'(HDR_BITS)) begin
        tx_q <= {tx_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign miso_o     = rd_act_q & tx_q[DATA_W-1];
  assign gap_busy_o = (gap_q != '0);
  assign bit_cnt_o  = cnt_q;
endmodule

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
  import spi_cfg_pkg::*;
#(
  parameter int NUM_GP  = 4,
  parameter int GP_BASE = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DATA_W-1:0] mode_o
);
  logic              gkey_q, akey_q;
  logic [DATA_W-1:0] mode_q;
  logic [DATA_W-1:0] gp_q [NUM_GP];
  logic              wr_ok;

  assign wr_ok = wr_en_i && gkey_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gkey_q <= 1'b0;
      akey_q <= 1'b0;
      mode_q <= MODE_RST;
    end else begin
      if (wr_en_i && wr_addr_i == A_GKEY) gkey_q <= (wr_data_i == GKEY_VAL);
      if (wr_ok && wr_addr_i == A_AKEY)   akey_q <= (wr_data_i == AKEY_VAL);
      if (wr_ok && akey_q && wr_addr_i == A_MODE) mode_q <= wr_data_i;
    end
  end

  for (genvar gi = 0; gi < NUM_GP; gi++) begin : g_gp
    localparam logic [ADDR_W-1:0] GP_ADDR = ADDR_W'(GP_BASE + gi);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          gp_q[gi] <= '0;
      else if (wr_ok && wr_addr_i == GP_ADDR) gp_q[gi] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == A_GKEY)      rd_data_o = DATA_W'(gkey_q);
    else if (rd_addr_i == A_AKEY) rd_data_o = DATA_W'(akey_q);
    else if (rd_addr_i == A_MODE) rd_data_o = mode_q;
    else begin
      for (int i = 0; i < NUM_GP; i++)
        if (rd_addr_i == ADDR_W'(GP_BASE + i)) rd_data_o = gp_q[i];
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/spi_cfg_port.sv
module spi_cfg_port
  import spi_cfg_pkg::*;
#(
  parameter int NUM_GP      = 4,
  parameter int GP_BASE     = 0,
  parameter int GAP_CYC     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic csn_i,
  input  logic mosi_i,
  output logic miso_o,
  output logic locate_en_o,
  output logic tilt_en_o
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);

  logic sck_s, csn_s, mosi_s, sck_d;
  logic sel, sck_rise, sck_fall;
  logic wr_en, gap_busy;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data, mode;
  logic [CNT_W-1:0]  bit_cnt;

  spi_cfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sck (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sck_i), .q_o(sck_s));
  spi_cfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_csn (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(csn_i), .q_o(csn_s));
  spi_cfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(mosi_i), .q_o(mosi_s));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_d <= 1'b0;
    else         sck_d <= sck_s;
  end

  assign sel      = ~csn_s;
  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;

  spi_cfg_frame #(.GAP_CYC(GAP_CYC)) u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel), .rise_i(sck_rise),
    .fall_i(sck_fall), .mosi_i(mosi_s), .rd_data_i(rd_data),
    .rd_addr_o(rd_addr), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .miso_o(miso_o), .gap_busy_o(gap_busy),
    .bit_cnt_o(bit_cnt));

  spi_cfg_regs #(.NUM_GP(NUM_GP), .GP_BASE(GP_BASE)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .mode_o(mode));

  assign locate_en_o = (mode == MODE_ALIGN);
  assign tilt_en_o   = (mode == MODE_ALIGN);
endmodule

// File: rtl/spi_cfg_port_chk.sv
module spi_cfg_port_chk
  import spi_cfg_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel,
  input logic              miso_o,
  input logic              locate_en_o,
  input logic              wr_en,
  input logic              gap_busy,
  input logic [DATA_W-1:0] mode,
  input logic [CNT_W-1:0]  bit_cnt
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel && $past(!sel)) |-> !miso_o);
  // R10
  gap_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_busy |-> !miso_o);
  // R2
  commit_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> bit_cnt == CNT_W'(FRAME_BITS));
  // R9
  abort_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel |=> bit_cnt == '0);
  // R6
  mode_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode) |-> $past(wr_en));
  // R7
  align_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locate_en_o) |-> $past(wr_en));
endmodule

bind spi_cfg_port spi_cfg_port_chk #(.CNT_W($clog2(spi_cfg_pkg::FRAME_BITS + 1))) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sel(sel), .miso_o(miso_o),
  .locate_en_o(locate_en_o), .wr_en(wr_en), .gap_busy(gap_busy),
  .mode(mode), .bit_cnt(bit_cnt));

// File: tb/spi_cfg_port_bench.sv
module spi_cfg_port_bench;
  localparam int GAP = 16;
  localparam int HP  = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sck = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic miso, loc_en, tilt_en;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  spi_cfg_port #(.GAP_CYC(GAP)) u_spi_cfg_port (
    .clk_i(clk), .rst_ni(rst_ni), .sck_i(sck), .csn_i(csn), .mosi_i(mosi),
    .miso_o(miso), .locate_en_o(loc_en), .tilt_en_o(tilt_en));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    mosi = b; wait_clk(HP); sck = 1'b1; wait_clk(HP); sck = 1'b0;
  endtask

  task automatic do_write(input logic [1:0] cmd, input logic [5:0] a, input logic [7:0] d);
    logic [15:0] f;
    f = {cmd, a, d};
    csn = 1'b0; wait_clk(HP);
    for (int i = 15; i >= 0; i--) send_bit(f[i]);
    wait_clk(HP); csn = 1'b1; wait_clk(HP);
  endtask

  task automatic do_read(input logic [5:0] a, output logic [7:0] q);
    logic [7:0] h;
    h = {2'b10, a};
    csn = 1'b0; wait_clk(HP);
    for (int i = 7; i >= 0; i--) send_bit(h[i]);
    wait_clk(4);
    chk("R10", "miso during pause", int'(miso), 0);
    wait_clk(GAP + 16);
    for (int i = 7; i >= 0; i--) begin
      q[i] = miso; sck = 1'b1; wait_clk(HP); sck = 1'b0; wait_clk(HP);
    end
    csn = 1'b1; wait_clk(HP);
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a, input logic [7:0] exp);
    logic [7:0] q;
    do_read(a, q);
    chk(req, $sformatf("read 0x%0h", a), int'(q), int'(exp));
  endtask

  task automatic pulse_reset;
    rst_ni = 1'b0; wait_clk(3); rst_ni = 1'b1; wait_clk(3);
  endtask

  task automatic t_reset;
    pulse_reset();
    chk("R1", "miso after reset", int'(miso), 0);
    chk("R1", "locate after reset", int'(loc_en), 0);
    chk("R1", "tilt after reset", int'(tilt_en), 0);
    rd_chk("R8", 6'h10, 8'h01);
    rd_chk("R8", 6'h1B, 8'h00);
    rd_chk("R8", 6'h00, 8'h00);
  endtask

  task automatic t_locked;
    do_write(2'b01, 6'h01, 8'hC3);
    rd_chk("R4", 6'h01, 8'h00);
    do_write(2'b01, 6'h1B, 8'h12);
    rd_chk("R4", 6'h1B, 8'h00);
  endtask

  task automatic t_unlock_gp;
    do_write(2'b01, 6'h1B, 8'hEB);
    rd_chk("R4", 6'h1B, 8'h01);
    do_write(2'b01, 6'h00, 8'h5A);
    do_write(2'b01, 6'h01, 8'hA5);
    do_write(2'b01, 6'h03, 8'h80);
    rd_chk("R2", 6'h00, 8'h5A);
    rd_chk("R2", 6'h01, 8'hA5);
    rd_chk("R8", 6'h03, 8'h80);
    rd_chk("R3", 6'h3F, 8'h00);
    rd_chk("R3", 6'h05, 8'h00);
  endtask

  task automatic t_bad_cmd;
    do_write(2'b11, 6'h00, 8'h11);
    do_write(2'b00, 6'h01, 8'h22);
    rd_chk("R11", 6'h00, 8'h5A);
    rd_chk("R11", 6'h01, 8'hA5);
  endtask

  task automatic t_abort;
    logic [15:0] f;
    f = {2'b01, 6'h00, 8'hFF};
    csn = 1'b0; wait_clk(HP);
    for (int i = 15; i >= 6; i--) send_bit(f[i]);
    wait_clk(HP); csn = 1'b1; wait_clk(HP);
    rd_chk("R9", 6'h00, 8'h5A);
    f = {2'b01, 6'h00, 8'h3C};
    csn = 1'b0; wait_clk(HP);
    for (int i = 15; i >= 1; i--) send_bit(f[i]);
    wait_clk(HP); csn = 1'b1; wait_clk(HP);
    rd_chk("R9", 6'h00, 8'h5A);
    do_write(2'b01, 6'h00, 8'h3C);
    rd_chk("R9", 6'h00, 8'h3C);
  endtask

  task automatic t_align;
    do_write(2'b01, 6'h10, 8'h11);
    rd_chk("R6", 6'h10, 8'h01);
    chk("R6", "locate without mode key", int'(loc_en), 0);
    do_write(2'b01, 6'h11, 8'hAB);
    rd_chk("R6", 6'h11, 8'h01);
    do_write(2'b01, 6'h10, 8'h11);
    chk("R7", "locate in align", int'(loc_en), 1);
    chk("R7", "tilt in align", int'(tilt_en), 1);
    rd_chk("R7", 6'h10, 8'h11);
    do_write(2'b01, 6'h10, 8'h01);
    chk("R7", "locate after exit", int'(loc_en), 0);
    chk("R7", "tilt after exit", int'(tilt_en), 0);
    do_write(2'b01, 6'h11, 8'h00);
    rd_chk("R6", 6'h11, 8'h00);
    do_write(2'b01, 6'h10, 8'h11);
    chk("R6", "locate after mode key cleared", int'(loc_en), 0);
  endtask

  task automatic t_relock;
    do_write(2'b01, 6'h1B, 8'hEA);
    rd_chk("R5", 6'h1B, 8'h00);
    do_write(2'b01, 6'h00, 8'h77);
    rd_chk("R5", 6'h00, 8'h3C);
  endtask

  task automatic t_reset_again;
    do_write(2'b01, 6'h1B, 8'hEB);
    do_write(2'b01, 6'h11, 8'hAB);
    do_write(2'b01, 6'h10, 8'h11);
    chk("R7", "locate before reset", int'(loc_en), 1);
    pulse_reset();
    chk("R8", "locate after reset", int'(loc_en), 0);
    rd_chk("R8", 6'h10, 8'h01);
    rd_chk("R8", 6'h11, 8'h00);
    rd_chk("R8", 6'h1B, 8'h00);
    do_write(2'b01, 6'h02, 8'h99);
    rd_chk("R8", 6'h02, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_locked();
    t_unlock_gp();
    t_bad_cmd();
    t_abort();
    t_align();
    t_relock();
    t_reset_again();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule